// File: doc/BRIEF.md
# Dual-Modulus Swallow Controller

This block steers an external two-ratio prescaler so that a frequency synthesizer can divide by a programmable total ratio. Each rising edge of its clock is one output pulse of the prescaler. The block runs a main down-counter and a swallow down-counter side by side. While the swallow counter still has counts left, the modulus line stays low and the prescaler divides by P+1. Once the swallow counter is spent, the line goes high and the prescaler divides by P for the rest of the main count. At the end of the main count, the block emits a single-clock pulse that serves as the divided feedback for the phase detector. Both counters then reload, and the cycle repeats. The total division is therefore N·P + A.

Settings are written through a simple strobe into shadow registers. They take effect only when the counters next reload, so no cycle ever mixes old and new settings. Illegal settings are repaired when they are captured: a main count of zero becomes one, and a swallow count larger than the main count is cut down to it.

Top module: `swallow_ctrl`

## Requirements
- R1: While reset is asserted, `mc` and `fv` are both 0. After reset, the shadow settings return to the defaults N=8 and A=3, and the next cycles run with them.
- R2: `fv` is 1 for exactly one count clock in every cycle of N count clocks: the last one. It is 0 for the other N−1.
- R3: Within a cycle, `mc` is 0 for the first A count clocks and 1 for the remaining N−A. The prescaler therefore divides by P+1 A times and by P N−A times.
- R4: With A=0, `mc` is 1 for every count clock of the cycle.
- R5: With A=N, `mc` is 0 for every count clock of the cycle.
- R6: A `cfg_we` pulse in the middle of a cycle leaves that cycle unchanged. The new N and A apply from the cycle that follows the next `fv` pulse.
- R7: A written A greater than the written N is stored as A=N.
- R8: A written N of 0 is stored as N=1. With N=1, `fv` is 1 on every count clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock: one rising edge per prescaler output pulse |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_we | input | 1 | Strobe that captures cfg_n and cfg_a into the shadow registers |
| cfg_n | input | 8 | Main count N (unsigned; 0 is treated as 1) |
| cfg_a | input | 8 | Swallow count A (unsigned; capped at N) |
| mc | output | 1 | Modulus control: 0 selects divide by P+1, 1 selects divide by P |
| fv | output | 1 | One-clock pulse at the last count clock of each cycle |

## Verification
The cycle is checked one count clock at a time against the expected `mc`/`fv` pattern for several (N, A) pairs. These include a mid-range split, A=0 and A=N; together they separate an off-by-one on the swallow boundary from one on the terminal count. A write placed in the first clock of a cycle shows whether settings leak into a running cycle. Out-of-range writes (A above N, N of zero) show whether the capture repairs them. A reset in mid-run shows that both the outputs and the shadow settings return to their defaults.

// File: rtl/swc_pkg.sv
package swc_pkg;
  parameter int unsigned CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  // a zero main count would never terminate; run it as one
  function automatic cnt_t fix_n(cnt_t n);
    return (n == '0) ? cnt_t'(1) : n;
  endfunction

  // swallow count may not exceed the repaired main count
  function automatic cnt_t fix_a(cnt_t n, cnt_t a);
    cnt_t nn;
    nn = fix_n(n);
    return (a > nn) ? nn : a;
  endfunction
endpackage

// File: rtl/swc_rst_sync.sv
module swc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/swc_shadow.sv
module swc_shadow
  import swc_pkg::*;
#(
  parameter int N_RST = 8,
  parameter int A_RST = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cnt_t wr_n,
  input  cnt_t wr_a,
  output cnt_t sh_n,
  output cnt_t sh_a
);
  localparam cnt_t RST_N = fix_n(cnt_t'(N_RST));
  localparam cnt_t RST_A = fix_a(cnt_t'(N_RST), cnt_t'(A_RST));

  cnt_t n_d, a_d;

  always_comb begin
    n_d = sh_n;
    a_d = sh_a;
    if (wr_en) begin
      n_d = fix_n(wr_n);
      a_d = fix_a(wr_n, wr_a);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_n <= RST_N;
      sh_a <= RST_A;
    end else begin
      sh_n <= n_d;
      sh_a <= a_d;
    end
  end
endmodule

// File: rtl/swc_counter.sv
module swc_counter
  import swc_pkg::*;
#(
  parameter int N_RST = 8,
  parameter int A_RST = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  cnt_t ld_n,
  input  cnt_t ld_a,
  output logic mc,
  output logic fv
);
  localparam cnt_t RST_N  = fix_n(cnt_t'(N_RST));
  localparam cnt_t RST_A  = fix_a(cnt_t'(N_RST), cnt_t'(A_RST));
  localparam logic RST_MC = (RST_A == '0);
  localparam logic RST_FV = (RST_N == cnt_t'(1));

  cnt_t n_q, a_q, n_d, a_d;
  logic mc_q, fv_q, mc_d, fv_d;
  logic term;

  // n_q = count clocks left in the cycle, a_q = swallow counts left
  assign term = (n_q <= cnt_t'(1));

  always_comb begin
    if (term) begin
      n_d = ld_n;
      a_d = ld_a;
    end else begin
      n_d = n_q - cnt_t'(1);
      a_d = (a_q == '0) ? '0 : a_q - cnt_t'(1);
    end
    mc_d = (a_d == '0);
    fv_d = (n_d == cnt_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= RST_N;
      a_q  <= RST_A;
      mc_q <= RST_MC;
      fv_q <= RST_FV;
    end else begin
      n_q  <= n_d;
      a_q  <= a_d;
      mc_q <= mc_d;
      fv_q <= fv_d;
    end
  end

  assign mc = mc_q;
  assign fv = fv_q;
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swc_pkg::*;
#(
  parameter int N_RST = 8,
  parameter int A_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_n,
  input  logic [CNT_W-1:0] cfg_a,
  output logic             mc,
  output logic             fv
);
  logic srst_n;
  cnt_t sh_n, sh_a;

  swc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  swc_shadow #(.N_RST(N_RST), .A_RST(A_RST)) u_shadow (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (cfg_we),
    .wr_n  (cfg_n),
    .wr_a  (cfg_a),
    .sh_n  (sh_n),
    .sh_a  (sh_a)
  );

  swc_counter #(.N_RST(N_RST), .A_RST(A_RST)) u_cnt (
    .clk   (clk),
    .rst_n (srst_n),
    .ld_n  (sh_n),
    .ld_a  (sh_a),
    .mc    (mc),
    .fv    (fv)
  );
endmodule

// File: rtl/swallow_ctrl_chk.sv
module swallow_ctrl_chk
  import swc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic mc,
  input logic fv,
  input cnt_t sh_n,
  input cnt_t sh_a
);
  // R3: after a reload with a nonzero swallow count the prescaler starts at P+1
  p_mc_low_after_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && sh_a != '0) |=> !mc);

  // R3: once high, the modulus line stays high until the terminal count
  p_mc_holds_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc && !fv) |=> mc);

  // R4: a zero swallow count keeps the line high from the first clock
  p_a_zero_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && sh_a == '0) |=> mc);

  // R2: the terminal pulse is one clock wide unless the main count is one
  p_fv_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && sh_n != cnt_t'(1)) |=> !fv);

  // R6: shadow settings move only on a write strobe
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(sh_n) && $stable(sh_a)));

  // R7: stored swallow count never exceeds stored main count
  p_a_capped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_a <= sh_n);

  // R8: stored main count is never zero
  p_n_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sh_n != '0);
endmodule

bind swallow_ctrl swallow_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_we (cfg_we),
  .mc     (mc),
  .fv     (fv),
  .sh_n   (sh_n),
  .sh_a   (sh_a)
);

// File: tb/swallow_ctrl_tb.sv
`timescale 1ns/1ps
module swallow_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_n;
  logic [7:0] cfg_a;
  logic       mc;
  logic       fv;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  swallow_ctrl u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .cfg_n  (cfg_n),
    .cfg_a  (cfg_a),
    .mc     (mc),
    .fv     (fv)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_bit(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Expects the previous sample to have been the terminal clock.
  // Optionally writes new settings during the first clock of this cycle.
  task automatic check_cycle(string tag, int n, int a,
                             bit wr, int wn, int wa);
    bit bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      logic emc, efv;
      @(negedge clk);
      emc = (k >= a);
      efv = (k == n - 1);
      if (!bad && (mc !== emc || fv !== efv)) begin
        bad = 1;
        $display("FAIL %s: clock %0d of N=%0d A=%0d got mc=%b fv=%b expected mc=%b fv=%b",
                 tag, k, n, a, mc, fv, emc, efv);
      end
      cfg_we = 1'b0;
      if (wr && k == 0) begin
        cfg_we = 1'b1;
        cfg_n  = 8'(wn);
        cfg_a  = 8'(wa);
      end
    end
    n_checks++;
    if (bad) n_fail++;
  endtask

  task automatic sync_to_fv(string tag);
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (fv !== 1'b1 && guard < 600);
    if (guard >= 600) begin
      n_checks++;
      n_fail++;
      $display("FAIL %s: no fv pulse seen, got fv=%b expected 1", tag, fv);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R1 reset mc", mc, 1'b0);
    check_bit("R1 reset fv", fv, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_default();
    sync_to_fv("R1 defaults");
    check_cycle("R1 R2 R3 default N8 A3", 8, 3, 0, 0, 0);
  endtask

  task automatic t_late_apply();
    check_cycle("R6 running cycle kept", 8, 3, 1, 10, 4);
    check_cycle("R3 N10 A4 first", 10, 4, 0, 0, 0);
    check_cycle("R2 N10 A4 second", 10, 4, 0, 0, 0);
  endtask

  task automatic t_a_zero();
    check_cycle("R6 write 5/0", 10, 4, 1, 5, 0);
    check_cycle("R4 A zero", 5, 0, 0, 0, 0);
  endtask

  task automatic t_a_full();
    check_cycle("R6 write 6/6", 5, 0, 1, 6, 6);
    check_cycle("R5 A equals N", 6, 6, 0, 0, 0);
  endtask

  task automatic t_a_clamp();
    check_cycle("R6 write 4/9", 6, 6, 1, 4, 9);
    check_cycle("R7 A capped to N", 4, 4, 0, 0, 0);
  endtask

  task automatic t_n_zero();
    check_cycle("R6 write 0/0", 4, 4, 1, 0, 0);
    for (int i = 0; i < 3; i++)
      check_cycle("R8 N zero runs as one", 1, 0, 0, 0, 0);
  endtask

  task automatic t_leave_n_one();
    // a write during an N=1 cycle lands on its terminal clock; the
    // reload at that edge still uses the old shadow value
    @(negedge clk);
    cfg_we = 1'b1; cfg_n = 8'd3; cfg_a = 8'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    check_bit("R8 N one fv", fv, 1'b1);
    check_cycle("R2 R3 N3 A1", 3, 1, 0, 0, 0);
  endtask

  task automatic t_midrun_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R1 midrun reset mc", mc, 1'b0);
    check_bit("R1 midrun reset fv", fv, 1'b0);
    rst_n = 1'b1;
    sync_to_fv("R1 after midrun reset");
    check_cycle("R1 defaults restored", 8, 3, 0, 0, 0);
  endtask

  initial begin
    rst_n  = 1'b0;
    cfg_we = 1'b0;
    cfg_n  = 8'd0;
    cfg_a  = 8'd0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_default();
    t_late_apply();
    t_a_zero();
    t_a_full();
    t_a_clamp();
    t_n_zero();
    t_leave_n_one();
    t_midrun_reset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run not finished, got running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule